// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the bus-facing receiver of a two-wire serial slave that controls a small set of wiper and data registers. It oversamples the raw clock and data lines in the system clock domain and finds start and stop conditions. It shifts bytes in most significant bit first and checks the first byte of every transfer against a fixed type code and four strapped select pins. It answers each accepted byte by pulling the data line low in the acknowledge slot. The instruction byte and any following write data byte go to a command executor as one-cycle strobes.

For a read instruction, the executor raises `xfer_read` and supplies a six-bit value. The block then sends that value to the master as a data byte. While the executor reports a nonvolatile store in progress through `store_busy`, the block does not acknowledge its own address. A host can therefore poll with start and address until an acknowledge comes back.

The controller is one state machine with states IDLE, ADDR, ADDR_ACK, INSTR, INSTR_ACK, WDATA, WDATA_ACK, RDATA, RD_MACK and IGNORE. These are its transitions:
- A start moves any state to ADDR. A stop moves any state to IDLE.
- The clock fall that ends the eighth address bit moves ADDR to ADDR_ACK on a match while not busy, and to IGNORE otherwise.
- The fall that ends the acknowledge slot moves ADDR_ACK to INSTR.
- The fall after the eighth instruction bit moves INSTR to INSTR_ACK.
- The fall that ends that acknowledge slot moves INSTR_ACK to RDATA if `xfer_read` is high, and to WDATA otherwise.
- After eight bits, WDATA moves to WDATA_ACK and RDATA moves to RD_MACK.
- Both WDATA_ACK and RD_MACK move to IGNORE when their slot ends.
- IGNORE waits for the next start or stop.

Top module: `tws_front`

## Requirements
- R1: After reset the data line is released (`sda_drv_n` = 1) and neither `cmd_valid` nor `wdata_valid` is high.
- R2: A start is SDA falling while SCL is high. A start in any state, including in the middle of a byte, begins reception of a new address byte.
- R3: A stop (SDA rising while SCL is high) returns the block to idle with the data line released. Later clock pulses without a start produce no acknowledge.
- R4: The address byte is accepted only when bits 7:4 equal 4'b0101 and bits 3:0 equal `dev_sel`. The block then holds SDA low through the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R5: While `store_busy` is high, a matching address gets no acknowledge. Once `store_busy` is low again, the same address is acknowledged.
- R6: The second byte is acknowledged and appears on `cmd_byte` with `cmd_valid` high for exactly one clock.
- R7: If `xfer_read` is low at the end of the instruction acknowledge, the third byte is acknowledged. Its low six bits appear on `wdata` with `wdata_valid` high for one clock.
- R8: If `xfer_read` is high at the end of the instruction acknowledge, the block sends {2'b00, `xfer_rdata`} MSB first on the next eight clocks. It then releases SDA for the master's acknowledge.
- R9: The block changes its SDA drive only while SCL is low.
- R10: A byte that follows the write data byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line as seen on the wire |
| sda_drv_n | output | 1 | Open-drain drive: 0 pulls SDA low, 1 releases |
| dev_sel | input | 4 | Strapped low nibble of the address |
| store_busy | input | 1 | High while a nonvolatile store is running |
| cmd_valid | output | 1 | One-clock strobe for a received instruction byte |
| cmd_byte | output | 8 | Instruction byte |
| wdata_valid | output | 1 | One-clock strobe for a received write data byte |
| wdata | output | 6 | Six-bit write value |
| xfer_read | input | 1 | Executor marks the current instruction as a read |
| xfer_rdata | input | 6 | Value to return on a read |

## Verification
The assertions assume a well-formed bus. SDA never rises or falls while SCL is high except to signal a start or a stop. The master never drives a start or stop edge while the slave holds the line low. Each SCL level lasts many system clocks, so the two-stage synchronizer sees every edge. The bench keeps to this by driving the bus as a wired-AND of master and slave. It moves master data only at a quarter period into SCL low and holds every SCL phase for eight or more system clocks. For a restart, it releases SDA only while SCL is low.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_MACK,
        ST_IGNORE
    } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] cur,
    output logic [LINES-1:0] prev
);
    for (genvar ln = 0; ln < LINES; ln++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
                last  <= 1'b1;
            end else begin
                chain <= {chain[STAGES-2:0], raw[ln]};
                last  <= chain[STAGES-1];
            end
        end
        assign cur[ln]  = chain[STAGES-1];
        assign prev[ln] = last;
    end
endmodule

// File: rtl/tws_cond.sv
module tws_cond #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LINES = 2;
    logic [LINES-1:0] cur;
    logic [LINES-1:0] prev;

    tws_sync #(.STAGES(STAGES), .LINES(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({scl_raw, sda_raw}),
        .cur  (cur),
        .prev (prev)
    );

    always_comb begin
        scl_lvl   = cur[1];
        sda_lvl   = cur[0];
        scl_rise  = cur[1] & ~prev[1];
        scl_fall  = ~cur[1] & prev[1];
        start_evt = cur[1] & prev[1] & prev[0] & ~cur[0];
        stop_evt  = cur[1] & prev[1] & ~prev[0] & cur[0];
    end
endmodule

// File: rtl/tws_bitshift.sv
module tws_bitshift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_clr,
    input  logic              shift_rx,
    input  logic              shift_tx,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_bit,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_msb,
    output logic              byte_done
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] tx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            rx_byte <= '0;
            tx_sh   <= '1;
        end else begin
            if (bit_clr) begin
                cnt <= '0;
            end else if (scl_rise && (shift_rx || shift_tx) && cnt != FULL) begin
                cnt <= cnt + 1'b1;
            end
            if (scl_rise && shift_rx) begin
                rx_byte <= {rx_byte[BYTE_W-2:0], sda_bit};
            end
            if (tx_load) begin
                tx_sh <= tx_byte;
            end else if (shift_tx && scl_fall && cnt != FULL) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            end
        end
    end

    assign tx_msb    = tx_sh[BYTE_W-1];
    assign byte_done = (cnt == FULL);
endmodule

// File: rtl/tws_front.sv
module tws_front #(
    parameter int          STAGES  = 2,
    parameter int          DW      = 6,
    parameter logic [3:0]  ID_CODE = 4'b0101
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_drv_n,
    input  logic [3:0]    dev_sel,
    input  logic          store_busy,
    output logic          cmd_valid,
    output logic [7:0]    cmd_byte,
    output logic          wdata_valid,
    output logic [DW-1:0] wdata,
    input  logic          xfer_read,
    input  logic [DW-1:0] xfer_rdata
);
    import tws_pkg::*;

    localparam int PAD_W = BYTE_W - DW;

    tws_state_e state, state_nx;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic bit_clr, shift_rx, shift_tx, tx_load, tx_msb, byte_done;
    logic [BYTE_W-1:0] rx_byte;
    logic              addr_hit;

    tws_cond #(.STAGES(STAGES)) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_evt(start_evt),
        .stop_evt (stop_evt)
    );

    tws_bitshift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_clr  (bit_clr),
        .shift_rx (shift_rx),
        .shift_tx (shift_tx),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_bit  (sda_lvl),
        .tx_load  (tx_load),
        .tx_byte  ({{PAD_W{1'b0}}, xfer_rdata}),
        .rx_byte  (rx_byte),
        .tx_msb   (tx_msb),
        .byte_done(byte_done)
    );

    assign addr_hit = (rx_byte[7:4] == ID_CODE) && (rx_byte[3:0] == dev_sel) && !store_busy;

    // Controls for the shifter, derived from the current state
    always_comb begin
        shift_rx = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_WDATA);
        shift_tx = (state == ST_RDATA);
        tx_load  = scl_fall && (state == ST_INSTR_ACK) && xfer_read && !start_evt && !stop_evt;
        bit_clr  = start_evt ||
                   (scl_fall && ((state == ST_ADDR_ACK) || (state == ST_INSTR_ACK)));
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start_evt) begin
            state_nx = ST_ADDR;
        end else if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  state_nx = ST_INSTR;
                ST_INSTR:     if (byte_done) state_nx = ST_INSTR_ACK;
                ST_INSTR_ACK: state_nx = xfer_read ? ST_RDATA : ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: state_nx = ST_IGNORE;
                ST_RDATA:     if (byte_done) state_nx = ST_RD_MACK;
                ST_RD_MACK:   state_nx = ST_IGNORE;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // Registered strobes toward the executor
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid   <= 1'b0;
            cmd_byte    <= '0;
            wdata_valid <= 1'b0;
            wdata       <= '0;
        end else begin
            cmd_valid   <= 1'b0;
            wdata_valid <= 1'b0;
            if (!start_evt && !stop_evt && scl_fall && byte_done) begin
                if (state == ST_INSTR) begin
                    cmd_valid <= 1'b1;
                    cmd_byte  <= rx_byte;
                end
                if (state == ST_WDATA) begin
                    wdata_valid <= 1'b1;
                    wdata       <= rx_byte[DW-1:0];
                end
            end
        end
    end

    // Line drive: acknowledge slots pull low, read data follows the shifter
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_INSTR_ACK, ST_WDATA_ACK: sda_drv_n = 1'b0;
            ST_RDATA:                                sda_drv_n = tx_msb;
            default:                                 sda_drv_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/tws_front_chk.sv
module tws_front_chk (
    input logic                clk,
    input logic                rst_n,
    input tws_pkg::tws_state_e state,
    input logic                start_evt,
    input logic                stop_evt,
    input logic                scl_lvl,
    input logic                sda_drv_n,
    input logic                cmd_valid,
    input logic                wdata_valid
);
    import tws_pkg::*;

    // R2
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> state == ST_ADDR);

    // R3
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (state == ST_IDLE && sda_drv_n));

    // R6
    cmd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R7
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, wdata_valid}));

    // R9
    drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drv_n) |-> !scl_lvl);
endmodule

bind tws_front tws_front_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .scl_lvl    (scl_lvl),
    .sda_drv_n  (sda_drv_n),
    .cmd_valid  (cmd_valid),
    .wdata_valid(wdata_valid)
);

// File: tb/tws_front_tb.sv
module tws_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QTR = 4;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_drv_n;
    logic [3:0] dev_sel = 4'hA;
    logic       store_busy = 1'b0;
    logic       cmd_valid, wdata_valid;
    logic [7:0] cmd_byte;
    logic [5:0] wdata;
    logic       xfer_read;
    logic [5:0] xfer_rdata;
    logic [5:0] rd_val = 6'h2D;
    logic       sda_line;

    int checks = 0;
    int fails  = 0;
    int cmd_cnt = 0;
    int wd_cnt  = 0;
    int bad_edges = 0;
    logic [7:0] last_cmd = 8'h00;
    logic [5:0] last_wd  = 6'h00;
    logic       done = 1'b0;
    logic       prev_drv = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line   = sda_m & sda_drv_n;
    assign xfer_read  = (last_cmd[7:4] == 4'h9) || (last_cmd[7:4] == 4'hB);
    assign xfer_rdata = rd_val;

    tws_front u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_drv_n  (sda_drv_n),
        .dev_sel    (dev_sel),
        .store_busy (store_busy),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .wdata_valid(wdata_valid),
        .wdata      (wdata),
        .xfer_read  (xfer_read),
        .xfer_rdata (xfer_rdata)
    );

    always @(posedge clk) begin
        if (cmd_valid)   begin cmd_cnt <= cmd_cnt + 1; last_cmd <= cmd_byte; end
        if (wdata_valid) begin wd_cnt <= wd_cnt + 1;   last_wd  <= wdata;    end
        if (rst_n && sda_drv_n !== prev_drv && scl_m) bad_edges <= bad_edges + 1;
        prev_drv <= sda_drv_n;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(QTR);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_m = b;    wait_clk(QTR);
        scl_m = 1'b1; wait_clk(HALF/2);
        seen = sda_line; wait_clk(HALF/2);
        scl_m = 1'b0; wait_clk(QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(1'b1, s);
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        logic s;
        int c0;
        wait_clk(5);
        // R1 reset state
        check(sda_drv_n === 1'b1, "R1 drv", sda_drv_n, 1);
        check(cmd_valid === 1'b0 && wdata_valid === 1'b0, "R1 strobes", cmd_valid, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R4 sweep of every address byte against one strap value
        for (int a = 0; a < 256; a++) begin
            bus_start();
            send_byte(8'(a), ack);
            bus_stop();
            check(ack == (a == 8'h5A), "R4 sweep", ack, (a == 8'h5A));
        end
        // R4 sweep of straps, near misses on the type code
        for (int sv = 0; sv < 16; sv++) begin
            dev_sel = 4'(sv);
            bus_start(); send_byte({4'b0101, 4'(sv)}, ack); bus_stop();
            check(ack == 1'b1, "R4 strap hit", ack, 1);
            bus_start(); send_byte({4'b0111, 4'(sv)}, ack); bus_stop();
            check(ack == 1'b0, "R4 type miss", ack, 0);
            bus_start(); send_byte({4'b0101, 4'(sv) ^ 4'b1000}, ack); bus_stop();
            check(ack == 1'b0, "R4 strap miss", ack, 0);
        end
        dev_sel = 4'h3;

        // R5 busy polling
        store_busy = 1'b1;
        for (int k = 0; k < 3; k++) begin
            bus_start(); send_byte(8'h53, ack); bus_stop();
            check(ack == 1'b0, "R5 busy nack", ack, 0);
        end
        store_busy = 1'b0;
        bus_start(); send_byte(8'h53, ack); bus_stop();
        check(ack == 1'b1, "R5 ready ack", ack, 1);

        // R6 R7 R10 write transfer
        for (int v = 0; v < 64; v += 9) begin
            c0 = cmd_cnt;
            bus_start();
            send_byte(8'h53, ack);
            send_byte(8'hA1, ack);
            check(ack == 1'b1, "R6 instr ack", ack, 1);
            check(cmd_cnt == c0 + 1 && last_cmd == 8'hA1, "R6 cmd byte", last_cmd, 8'hA1);
            send_byte({2'b00, 6'(v)}, ack);
            check(ack == 1'b1, "R7 data ack", ack, 1);
            check(last_wd == 6'(v), "R7 wdata", last_wd, v);
            send_byte(8'h15, ack);
            check(ack == 1'b0, "R10 extra byte", ack, 0);
            bus_stop();
        end

        // R8 reads with varying values
        for (int v = 0; v < 64; v += 7) begin
            rd_val = 6'(v ^ 6'h2A);
            bus_start();
            send_byte(8'h53, ack);
            send_byte(8'h94, ack);
            check(ack == 1'b1, "R8 instr ack", ack, 1);
            read_byte(rb);
            check(rb == {2'b00, 6'(v ^ 6'h2A)}, "R8 read data", rb, {2'b00, 6'(v ^ 6'h2A)});
            check(sda_drv_n === 1'b1, "R8 release", sda_drv_n, 1);
            bus_stop();
        end

        // R2 restart in the middle of the instruction byte
        c0 = cmd_cnt;
        bus_start();
        send_byte(8'h53, ack);
        clock_bit(1'b1, s); clock_bit(1'b0, s); clock_bit(1'b1, s);
        bus_start();
        send_byte(8'h53, ack);
        check(ack == 1'b1, "R2 restart addr", ack, 1);
        send_byte(8'hC6, ack);
        check(cmd_cnt == c0 + 1 && last_cmd == 8'hC6, "R2 restart cmd", last_cmd, 8'hC6);
        bus_stop();

        // R3 clocks after stop get no acknowledge
        send_byte(8'h53, ack);
        check(ack == 1'b0, "R3 after stop", ack, 0);
        check(sda_drv_n === 1'b1, "R3 released", sda_drv_n, 1);

        // R9 drive edges while clock high
        check(bad_edges == 0, "R9 drive timing", bad_edges, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule